// File: doc/BRIEF.md
# Special register access unit

This unit sits beside the execute stage of a 32-bit core and serves its move-to and move-from special-register instructions. A special-register address combines a group and a number as `(group << 11) + number`. The unit decodes that address, holds a small set of system registers, returns fixed identity and configuration words, and owns a 16-bank by 32-entry shadow register array. Bank 0 of that array is the live register file: a side port gives the pipeline its combinational operand read and its result write against bank 0. Every bank, bank 0 included, can also be reached by address through a linear window of the special-register space.

The power register drives a three-state power sequencer with states RUN, DOZE and SLEEP. In RUN, a write to the power register with the sleep bit set moves to SLEEP (transition RUN_TO_SLEEP). A write with only the doze bit set moves to DOZE (RUN_TO_DOZE). In either state the halt request to the pipeline is raised, and the address of the instruction after the halting write is presented as the resume address. A later power write with the enable bits set moves between the two halted states (DOZE_TO_SLEEP, SLEEP_TO_DOZE). A wake or exception input returns the sequencer to RUN (WAKE_TO_RUN) and clears both enable bits. Any other cycle holds the current state.

Reads are combinational: read data reflects the address in the same cycle while the read strobe is high, and is zero otherwise. Writes take effect at the next clock edge.

Top module: `spr_unit`

## Requirements
- R1: After reset the system registers and every shadow entry read as zero, halt is low and the resume address is zero.
- R2: Address 11 (group 0) is a read/write vector base register; every other write leaves it unchanged.
- R3: Address 128 reads the core index 0, and address 129 reads the core count 1; writes to them have no effect.
- R4: Addresses 1024 to 1535 map shadow entry (bank = (addr-1024)/32, register = (addr-1024)%32), readable and writable.
- R5: Bank 0 is the pipeline's register file: the side-port read of register n returns the value at address 1024+n, and a side-port write to register n is visible there on the next cycle.
- R6: When a window write and a side-port write hit the same bank-0 register in one cycle, the window write wins.
- R7: The interrupt mask register at 18432 (group 9, number 0) ORs each written value into its contents; its bits are never cleared by a write.
- R8: The power register at 16384 (group 8, number 0) stores the whole written word. If bit 4 (doze) or bit 5 (sleep) is set and no wake or exception arrives in that cycle, halt is high from the next cycle and the resume address becomes pc_i + 4.
- R9: Halt stays high until wake_i or exc_i is sampled high. That cycle clears power bits 4 and 5, keeps the other bits, and drops halt on the next cycle. This also holds when it coincides with a halting power write.
- R10: Reads of undecoded addresses (including 1023, 1536 and above) return zero, and writes to them change no readable state.
- R11: Address 1 reads a presence word with bit 0 and bit 9 (power unit present) set. Address 2 reads a configuration word with bit 12 (vector base present) set and bits 3:0 equal to the bank count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_addr_i | input | 16 | Special-register address |
| spr_wdata_i | input | 32 | Write data |
| spr_re_i | input | 1 | Read strobe |
| spr_we_i | input | 1 | Write strobe |
| spr_rdata_o | output | 32 | Read data, zero when the read strobe is low |
| pc_i | input | 32 | Address of the instruction doing the access |
| wake_i | input | 1 | External wake request |
| exc_i | input | 1 | Exception taken |
| halt_o | output | 1 | Halt request to the pipeline |
| resume_pc_o | output | 32 | Address to resume from after a halt |
| gpr_raddr_i | input | 5 | Side-port read register |
| gpr_rdata_o | output | 32 | Side-port read data (bank 0) |
| gpr_we_i | input | 1 | Side-port write strobe |
| gpr_waddr_i | input | 5 | Side-port write register |
| gpr_wdata_i | input | 32 | Side-port write data |

## Verification
Two pairs of functions can land in the same cycle. A window write and a pipeline write can target the same bank-0 register, and a halting power write can arrive together with a wake or exception. Both collisions are driven deliberately and then recur in a long random stretch. The bench's behavioural model applies the window write after the pipeline write and lets wake override the halting write. It compares read data, side-port data, halt and resume address against the design on every cycle.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int GROUP_SHIFT = 11;

    function automatic int spr_addr(input int group, input int number);
        return (group << GROUP_SHIFT) + number;
    endfunction

    localparam int A_PRESENCE = spr_addr(0, 1);
    localparam int A_CONFIG   = spr_addr(0, 2);
    localparam int A_VECBASE  = spr_addr(0, 11);
    localparam int A_COREIDX  = spr_addr(0, 128);
    localparam int A_CORECNT  = spr_addr(0, 129);
    localparam int A_WINDOW   = spr_addr(0, 1024);
    localparam int A_POWER    = spr_addr(8, 0);
    localparam int A_IRQMASK  = spr_addr(9, 0);

    localparam int PWR_DOZE_BIT  = 4;
    localparam int PWR_SLEEP_BIT = 5;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PRESENCE,
        SEL_CONFIG,
        SEL_VECBASE,
        SEL_COREIDX,
        SEL_CORECNT,
        SEL_WINDOW,
        SEL_POWER,
        SEL_IRQMASK
    } spr_sel_e;

    typedef enum logic [1:0] {
        PS_RUN,
        PS_DOZE,
        PS_SLEEP
    } pwr_state_e;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_BANKS = 16,
    parameter int NUM_REGS  = 32,
    localparam int FLAT_W   = $clog2(NUM_BANKS * NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output spr_sel_e          sel_o,
    output logic [FLAT_W-1:0] flat_o
);
    localparam int WIN_SIZE = NUM_BANKS * NUM_REGS;
    localparam int WIN_END  = A_WINDOW + WIN_SIZE;

    logic [31:0] a32;
    logic        in_win;

    always_comb begin
        a32    = 32'(addr_i);
        in_win = (a32 >= 32'(A_WINDOW)) && (a32 < 32'(WIN_END));
        flat_o = FLAT_W'(addr_i - ADDR_W'(A_WINDOW));
        sel_o  = SEL_NONE;
        if (in_win)                         sel_o = SEL_WINDOW;
        else if (a32 == 32'(A_PRESENCE))    sel_o = SEL_PRESENCE;
        else if (a32 == 32'(A_CONFIG))      sel_o = SEL_CONFIG;
        else if (a32 == 32'(A_VECBASE))     sel_o = SEL_VECBASE;
        else if (a32 == 32'(A_COREIDX))     sel_o = SEL_COREIDX;
        else if (a32 == 32'(A_CORECNT))     sel_o = SEL_CORECNT;
        else if (a32 == 32'(A_POWER))       sel_o = SEL_POWER;
        else if (a32 == 32'(A_IRQMASK))     sel_o = SEL_IRQMASK;
    end

endmodule

// File: rtl/spr_shadow_rf.sv
module spr_shadow_rf #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 16,
    parameter int NUM_REGS  = 32,
    localparam int DEPTH    = NUM_BANKS * NUM_REGS,
    localparam int FLAT_W   = $clog2(DEPTH),
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we_i,
    input  logic [FLAT_W-1:0] win_addr_i,
    input  logic [DATA_W-1:0] win_wdata_i,
    output logic [DATA_W-1:0] win_rdata_o,
    input  logic              pipe_we_i,
    input  logic [IDX_W-1:0]  pipe_waddr_i,
    input  logic [DATA_W-1:0] pipe_wdata_i,
    input  logic [IDX_W-1:0]  pipe_raddr_i,
    output logic [DATA_W-1:0] pipe_rdata_o
);
    localparam int BANK_W = FLAT_W - IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Window write is issued last so it overrides a same-entry pipeline write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (pipe_we_i) mem[{{BANK_W{1'b0}}, pipe_waddr_i}] <= pipe_wdata_i;
            if (win_we_i)  mem[win_addr_i] <= win_wdata_i;
        end
    end

    assign win_rdata_o  = mem[win_addr_i];
    assign pipe_rdata_o = mem[{{BANK_W{1'b0}}, pipe_raddr_i}];

    // R6: window write takes the entry when both ports hit it
    p_window_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we_i && pipe_we_i && (win_addr_i == {{BANK_W{1'b0}}, pipe_waddr_i}))
        |=> (mem[$past(win_addr_i)] == $past(win_wdata_i)));

    // R5: a lone pipeline write lands in bank 0
    p_pipe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_we_i && !win_we_i)
        |=> (mem[{{BANK_W{1'b0}}, $past(pipe_waddr_i)}] == $past(pipe_wdata_i)));

endmodule

// File: rtl/spr_power_seq.sv
module spr_power_seq
    import spr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic              wake_i,
    input  logic              exc_i,
    output logic [DATA_W-1:0] pwr_q_o,
    output logic              halt_o,
    output logic [DATA_W-1:0] resume_pc_o
);
    pwr_state_e        state_q, state_d;
    logic              wake, go_doze, go_sleep;
    logic [DATA_W-1:0] pwr_d;

    always_comb begin
        wake     = wake_i | exc_i;
        go_doze  = pwr_we_i & wdata_i[PWR_DOZE_BIT];
        go_sleep = pwr_we_i & wdata_i[PWR_SLEEP_BIT];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (!wake && go_sleep)     state_d = PS_SLEEP;
                else if (!wake && go_doze) state_d = PS_DOZE;
            end
            PS_DOZE, PS_SLEEP: begin
                if (wake)          state_d = PS_RUN;
                else if (go_sleep) state_d = PS_SLEEP;
                else if (go_doze)  state_d = PS_DOZE;
            end
            default: state_d = PS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        halt_o = (state_q != PS_RUN);
    end

    always_comb begin
        pwr_d = pwr_we_i ? wdata_i : pwr_q_o;
        if (wake) begin
            pwr_d[PWR_DOZE_BIT]  = 1'b0;
            pwr_d[PWR_SLEEP_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q_o     <= '0;
            resume_pc_o <= '0;
        end else begin
            pwr_q_o <= pwr_d;
            if ((go_doze || go_sleep) && !wake) resume_pc_o <= pc_i + DATA_W'(4);
        end
    end

    // R8: enabling doze or sleep without a wake halts on the next cycle
    p_halt_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((go_doze || go_sleep) && !wake) |=> (halt_o && (resume_pc_o == $past(pc_i) + DATA_W'(4))));

    // R9: wake or exception releases the halt and clears both enable bits
    p_wake_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!halt_o && !pwr_q_o[PWR_DOZE_BIT] && !pwr_q_o[PWR_SLEEP_BIT]));

    // R9: halt holds while nothing touches the sequencer
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !wake && !pwr_we_i) |=> (halt_o && $stable(pwr_q_o)));

endmodule

// File: rtl/spr_unit.sv
module spr_unit
    import spr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 16,
    parameter int NUM_REGS  = 32,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] spr_addr_i,
    input  logic [DATA_W-1:0] spr_wdata_i,
    input  logic              spr_re_i,
    input  logic              spr_we_i,
    output logic [DATA_W-1:0] spr_rdata_o,
    input  logic [DATA_W-1:0] pc_i,
    input  logic              wake_i,
    input  logic              exc_i,
    output logic              halt_o,
    output logic [DATA_W-1:0] resume_pc_o,
    input  logic [IDX_W-1:0]  gpr_raddr_i,
    output logic [DATA_W-1:0] gpr_rdata_o,
    input  logic              gpr_we_i,
    input  logic [IDX_W-1:0]  gpr_waddr_i,
    input  logic [DATA_W-1:0] gpr_wdata_i
);
    localparam int FLAT_W = $clog2(NUM_BANKS * NUM_REGS);
    localparam logic [DATA_W-1:0] PRESENCE_WORD = DATA_W'((1 << 9) | 1);
    localparam logic [DATA_W-1:0] CONFIG_WORD   = DATA_W'((1 << 12) | ((NUM_BANKS - 1) & 15));

    spr_sel_e          sel;
    logic [FLAT_W-1:0] flat;
    logic [DATA_W-1:0] vecbase_q, irqmask_q, pwr_q, win_rdata, rd_mux;

    spr_decode #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS)
    ) u_dec (
        .addr_i(spr_addr_i), .sel_o(sel), .flat_o(flat)
    );

    spr_shadow_rf #(
        .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .win_we_i(spr_we_i && (sel == SEL_WINDOW)),
        .win_addr_i(flat), .win_wdata_i(spr_wdata_i), .win_rdata_o(win_rdata),
        .pipe_we_i(gpr_we_i), .pipe_waddr_i(gpr_waddr_i), .pipe_wdata_i(gpr_wdata_i),
        .pipe_raddr_i(gpr_raddr_i), .pipe_rdata_o(gpr_rdata_o)
    );

    spr_power_seq #(.DATA_W(DATA_W)) u_pwr (
        .clk(clk), .rst_n(rst_n),
        .pwr_we_i(spr_we_i && (sel == SEL_POWER)),
        .wdata_i(spr_wdata_i), .pc_i(pc_i),
        .wake_i(wake_i), .exc_i(exc_i),
        .pwr_q_o(pwr_q), .halt_o(halt_o), .resume_pc_o(resume_pc_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vecbase_q <= '0;
            irqmask_q <= '0;
        end else if (spr_we_i) begin
            if (sel == SEL_VECBASE) vecbase_q <= spr_wdata_i;
            if (sel == SEL_IRQMASK) irqmask_q <= irqmask_q | spr_wdata_i;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_PRESENCE: rd_mux = PRESENCE_WORD;
            SEL_CONFIG:   rd_mux = CONFIG_WORD;
            SEL_VECBASE:  rd_mux = vecbase_q;
            SEL_COREIDX:  rd_mux = '0;
            SEL_CORECNT:  rd_mux = DATA_W'(1);
            SEL_WINDOW:   rd_mux = win_rdata;
            SEL_POWER:    rd_mux = pwr_q;
            SEL_IRQMASK:  rd_mux = irqmask_q;
            default:      rd_mux = '0;
        endcase
        spr_rdata_o = spr_re_i ? rd_mux : '0;
    end

    // R7: mask bits never fall
    p_mask_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irqmask_q & $past(irqmask_q)) == $past(irqmask_q)));

    // R2: vector base only changes on its own write
    p_vecbase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(spr_we_i && (sel == SEL_VECBASE)) |=> $stable(vecbase_q));

    // R3: identity constants at the port
    p_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_re_i && (32'(spr_addr_i) == 32'(A_CORECNT))) |-> (spr_rdata_o == DATA_W'(1)));

    // R5: side-port read agrees with the bank-0 window entry
    p_bank0_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_re_i && (sel == SEL_WINDOW) && (flat == FLAT_W'(gpr_raddr_i)))
        |-> (spr_rdata_o == gpr_rdata_o));

endmodule

// File: tb/tb_spr_unit.sv
`timescale 1ns/1ps
module tb_spr_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic [31:0] wdata, pc;
    logic        re, we, wake, exc, gwe;
    logic [4:0]  graddr, gwaddr;
    logic [31:0] gwdata;
    logic [31:0] rdata, gpr_rdata, resume_pc;
    logic        halt;

    always #2.5 clk = ~clk;

    spr_unit dut (
        .clk(clk), .rst_n(rst_n), .spr_addr_i(addr), .spr_wdata_i(wdata),
        .spr_re_i(re), .spr_we_i(we), .spr_rdata_o(rdata), .pc_i(pc),
        .wake_i(wake), .exc_i(exc), .halt_o(halt), .resume_pc_o(resume_pc),
        .gpr_raddr_i(graddr), .gpr_rdata_o(gpr_rdata), .gpr_we_i(gwe),
        .gpr_waddr_i(gwaddr), .gpr_wdata_i(gwdata)
    );

    integer vectors = 0, miscompares = 0;
    bit     done = 0;

    logic [31:0] m_rf [512];
    logic [31:0] m_vec, m_pwr, m_mask, m_resume;
    bit          m_halt;

    function automatic logic [31:0] m_read(input int a);
        if (a >= 1024 && a < 1536) return m_rf[a - 1024];
        case (a)
            1:     return 32'h0000_0201;
            2:     return 32'h0000_100F;
            11:    return m_vec;
            128:   return 32'd0;
            129:   return 32'd1;
            16384: return m_pwr;
            18432: return m_mask;
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        addr = '0; wdata = '0; re = 0; we = 0; wake = 0; exc = 0;
        gwe = 0; gwaddr = '0; gwdata = '0; pc = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 512; i++) m_rf[i] = '0;
        m_vec = '0; m_pwr = '0; m_mask = '0; m_resume = '0; m_halt = 0;
    endtask

    // one cycle: compare in the middle of the low phase, update model at the edge
    task automatic step(input string tag);
        int a;
        #1;
        a = int'(addr);
        cmp(tag, "rdata", rdata, re ? m_read(a) : 32'd0);
        cmp(tag, "gpr_rdata", gpr_rdata, m_rf[graddr]);
        cmp(tag, "halt", {31'd0, halt}, {31'd0, m_halt});
        cmp(tag, "resume_pc", resume_pc, m_resume);
        @(posedge clk);
        if (gwe) m_rf[gwaddr] = gwdata;
        if (we) begin
            if (a >= 1024 && a < 1536) m_rf[a - 1024] = wdata;
            else if (a == 11) m_vec = wdata;
            else if (a == 18432) m_mask = m_mask | wdata;
            else if (a == 16384) begin
                m_pwr = wdata;
                if ((wdata[4] || wdata[5]) && !(wake || exc)) begin
                    m_halt = 1; m_resume = pc + 32'd4;
                end
            end
        end
        if (wake || exc) begin
            m_pwr[5:4] = 2'b00; m_halt = 0;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input int a, input string tag);
        addr = 16'(a); re = 1; step(tag);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        addr = 16'(a); wdata = d; we = 1; step(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        rst_n = 0; rd(11, "R1"); rst_n = 1;
        rd(16384, "R1"); rd(18432, "R1"); rd(1024 + 37, "R1");
        graddr = 5'd31; step("R1");

        // R2
        wr(11, 32'hABCD_0100, "R2"); rd(11, "R2");
        wr(12, 32'h1111_2222, "R2"); rd(11, "R2");
        // R3
        rd(128, "R3"); rd(129, "R3");
        wr(128, 32'hFFFF_FFFF, "R3"); rd(128, "R3");
        // R11
        rd(1, "R11"); rd(2, "R11");
        // R4
        wr(1024 + 3*32 + 7, 32'hDEAD_BEEF, "R4"); rd(1024 + 3*32 + 7, "R4");
        wr(1535, 32'h5A5A_0001, "R4"); rd(1535, "R4");
        // R5
        gwe = 1; gwaddr = 5'd9; gwdata = 32'h0000_0909; step("R5");
        rd(1024 + 9, "R5");
        wr(1024 + 4, 32'h4444_0004, "R5");
        graddr = 5'd4; step("R5");
        // R6: collision on bank-0 register 12
        gwe = 1; gwaddr = 5'd12; gwdata = 32'hBAD0_BAD0;
        wr(1024 + 12, 32'h600D_600D, "R6");
        graddr = 5'd12; step("R6");
        // R7
        wr(18432, 32'h0000_000F, "R7"); wr(18432, 32'h0000_00F0, "R7");
        wr(18432, 32'h0, "R7"); rd(18432, "R7");
        // R10
        wr(1536, 32'h7777_7777, "R10"); rd(1536, "R10"); rd(1535, "R10");
        rd(1023, "R10"); rd(16'h7FFF, "R10"); wr(3, 32'h1, "R10"); rd(3, "R10");
        // R8: doze
        pc = 32'h0000_0100; wr(16384, 32'h0000_0013, "R8");
        rd(16384, "R8"); step("R8"); step("R8");
        // R9: wake
        wake = 1; step("R9"); rd(16384, "R9");
        // R8/R9: sleep released by exception
        pc = 32'h0000_2000; wr(16384, 32'h0000_002A, "R8");
        step("R9"); exc = 1; step("R9"); rd(16384, "R9");
        // R9: halting write coincides with wake
        pc = 32'h0000_3000; wake = 1; wr(16384, 32'h0000_00B1, "R9");
        rd(16384, "R9");

        // random stretch
        for (int n = 0; n < 600; n++) begin
            int pick = $urandom_range(0, 9);
            case (pick)
                0: addr = 16'd11;
                1: addr = 16'd16384;
                2: addr = 16'd18432;
                3: addr = 16'(1024 + $urandom_range(0, 31));
                4, 5: addr = 16'(1024 + $urandom_range(0, 511));
                6: addr = 16'($urandom_range(1536, 1600));
                7: addr = 16'($urandom_range(127, 130));
                default: addr = 16'($urandom_range(0, 65535));
            endcase
            wdata  = $urandom;
            re     = 1'($urandom_range(0, 1));
            we     = 1'($urandom_range(0, 1));
            pc     = $urandom & 32'hFFFF_FFFC;
            wake   = ($urandom_range(0, 9) == 0);
            exc    = ($urandom_range(0, 14) == 0);
            gwe    = 1'($urandom_range(0, 1));
            gwaddr = 5'($urandom_range(0, 31));
            gwdata = $urandom;
            graddr = 5'($urandom_range(0, 31));
            step("R4");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule